// File: doc/BRIEF.md
# Hamming-Protected Parallel 4-Point FFT

This block runs four independent 4-point complex FFT channels side by side and guards them against a single soft error using only three extra FFT channels. Each extra channel transforms the sum of a subset of three original input vectors. Because the DFT is linear, its output must equal the same sum of the original outputs. Three such checks form a 3-bit syndrome. Any single faulty channel, original or redundant, produces a distinct non-zero syndrome.

When an original channel is flagged, its output is replaced by one of its checks: that check's redundant output minus the other two original outputs it covers. When a redundant channel is flagged, the original results pass through unchanged. A transaction is accepted with a valid/ready handshake. The result appears after a fixed latency together with an error flag and the index of the faulty channel. For test, a fault-injection port flips bits in one output bin of a chosen channel.

The controller walks five named states. IDLE accepts a transaction (IDLE→XFORM on in_valid). XFORM registers all seven transforms (XFORM→CHECK, unconditional). CHECK registers the syndrome (CHECK→FIX, unconditional). FIX registers the corrected outputs (FIX→HOLD, unconditional). HOLD presents the result (HOLD→IDLE on out_ready).

Top module: `par_fft_ecc`

## Requirements
- R1: Every channel output bin k equals the sum over n of x[n]·(−j)^(n·k), exactly, in DW+2 bits. Flat index: sample n of channel c sits at slice (c·4+n). Bin k of channel c sits at slice (c·4+k).
- R2: The three checks cover original channels {0,1,2}, {0,1,3} and {0,2,3}, in that order. Redundant channel j transforms the sum of its check's inputs. A check whose redundant output differs from the matching sum of original outputs, in any bin, real or imaginary, sets its syndrome bit. The syndrome is written with the first check as its MSB. With no injected fault the syndrome is zero.
- R3: The syndrome maps to err_chan as follows: 111→0, 110→1, 101→2, 011→3, 100→4, 010→5, 001→6. Indices 4 to 6 are the redundant channels 0 to 2.
- R4: With a single faulty original channel, out_re/out_im equal the fault-free transforms of all four channels, and err_flag is 1.
- R5: With a single faulty redundant channel, the original outputs pass unchanged and err_flag is 1.
- R6: With no fault, err_flag is 0 and err_chan is 0.
- R7: in_ready is high only in IDLE. out_valid rises exactly 4 clock edges after the accepting edge.
- R8: While out_valid is high and out_ready is low, the outputs, err_flag and err_chan stay stable and in_ready stays low.
- R9: Injection fields are captured with the accepted transaction. When inj_en is 1, inj_mask is XORed into the real part of bin inj_bin of channel inj_chan (0–6). inj_en=0, a zero mask, or inj_chan=7 has no effect.
- R10: Reset, active low and asynchronous, returns to IDLE with in_ready=1, out_valid=0 and err_flag=0, even mid-transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction valid |
| in_ready | output | 1 | Block ready to accept (IDLE) |
| in_re | input | 16*DW | Real parts, 4 channels × 4 samples |
| in_im | input | 16*DW | Imaginary parts, same layout |
| inj_en | input | 1 | Enable fault injection for this transaction |
| inj_chan | input | 3 | Channel to corrupt (0–3 original, 4–6 redundant) |
| inj_bin | input | 2 | Output bin to corrupt |
| inj_mask | input | DW+2 | XOR mask for the bin's real part |
| out_valid | output | 1 | Corrected result valid (HOLD) |
| out_ready | input | 1 | Consumer accepts result |
| out_re | output | 16*(DW+2) | Corrected real outputs, 4 channels × 4 bins |
| out_im | output | 16*(DW+2) | Corrected imaginary outputs |
| err_flag | output | 1 | Non-zero syndrome seen |
| err_chan | output | 3 | Index of the faulty channel |

## Verification
A corrupted transform register shows up on err_flag and err_chan in the same result that carries it, 4 edges after acceptance. A faulty syndrome or decode shows up in that same result as a wrong err_chan, or as out_re/out_im differing from the fault-free transform in the rebuilt channel. A wrong controller state shows up as out_valid arriving early or late against the 4-edge count, as in_ready high while busy, or as a held result changing under back-pressure. Each of these is visible in the cycle it occurs.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

    localparam int NCH  = 4;           // original channels
    localparam int NRED = 3;           // redundant channels / checks
    localparam int NALL = NCH + NRED;
    localparam int NPT  = 4;           // transform points
    localparam int CHW  = 3;           // channel index width
    localparam int BINW = 2;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_XFORM = 3'd1,
        S_CHECK = 3'd2,
        S_FIX   = 3'd3,
        S_HOLD  = 3'd4
    } pfe_state_e;

    // check chk covers original channel ch (Hamming SEC pattern)
    function automatic logic covers(input int chk, input int ch);
        logic r;
        unique case (chk)
            0:       r = (ch != 3);
            1:       r = (ch != 2);
            default: r = (ch != 1);
        endcase
        return r;
    endfunction

    // syndrome produced by a fault in channel ch, first check at MSB
    function automatic logic [NRED-1:0] code_of(input int ch);
        logic [NRED-1:0] s;
        s = '0;
        if (ch < NCH) begin
            for (int j = 0; j < NRED; j++) s[NRED-1-j] = covers(j, ch);
        end else begin
            s[NRED-1-(ch-NCH)] = 1'b1;
        end
        return s;
    endfunction

    // first check that covers an original channel; used to rebuild it
    function automatic int fix_chk(input int ch);
        int p;
        p = NRED - 1;
        for (int j = NRED - 1; j >= 0; j--) if (covers(j, ch)) p = j;
        return p;
    endfunction

endpackage

// File: rtl/pfe_fft4.sv
module pfe_fft4
    import pfe_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic [NPT*IW-1:0]     x_re,
    input  logic [NPT*IW-1:0]     x_im,
    output logic [NPT*(IW+2)-1:0] y_re,
    output logic [NPT*(IW+2)-1:0] y_im
);
    localparam int OW = IW + 2;

    logic signed [OW-1:0] xr [NPT];
    logic signed [OW-1:0] xi [NPT];
    logic signed [OW-1:0] ar, ai, br, bi, cr, ci, dr, di;

    always_comb begin
        for (int n = 0; n < NPT; n++) begin
            xr[n] = OW'($signed(x_re[n*IW +: IW]));
            xi[n] = OW'($signed(x_im[n*IW +: IW]));
        end
        // first radix-2 stage
        ar = xr[0] + xr[2];
        ai = xi[0] + xi[2];
        br = xr[0] - xr[2];
        bi = xi[0] - xi[2];
        cr = xr[1] + xr[3];
        ci = xi[1] + xi[3];
        dr = xr[1] - xr[3];
        di = xi[1] - xi[3];
        // second stage; the -j twiddle is a swap and a negation
        y_re[0*OW +: OW] = ar + cr;
        y_im[0*OW +: OW] = ai + ci;
        y_re[1*OW +: OW] = br + di;
        y_im[1*OW +: OW] = bi - dr;
        y_re[2*OW +: OW] = ar - cr;
        y_im[2*OW +: OW] = ai - ci;
        y_re[3*OW +: OW] = br - di;
        y_im[3*OW +: OW] = bi + dr;
    end

endmodule

// File: rtl/pfe_check.sv
module pfe_check
    import pfe_pkg::*;
#(
    parameter int OW = 14,
    parameter int RW = 16
) (
    input  logic [NCH*NPT*OW-1:0]  orig_re,
    input  logic [NCH*NPT*OW-1:0]  orig_im,
    input  logic [NRED*NPT*RW-1:0] red_re,
    input  logic [NRED*NPT*RW-1:0] red_im,
    output logic [NRED-1:0]        syn
);

    for (genvar j = 0; j < NRED; j++) begin : g_chk
        logic                 mism;
        logic signed [RW-1:0] sr, si;

        always_comb begin
            mism = 1'b0;
            sr   = '0;
            si   = '0;
            for (int k = 0; k < NPT; k++) begin
                sr = '0;
                si = '0;
                for (int c = 0; c < NCH; c++) begin
                    if (covers(j, c)) begin
                        sr = sr + RW'($signed(orig_re[(c*NPT+k)*OW +: OW]));
                        si = si + RW'($signed(orig_im[(c*NPT+k)*OW +: OW]));
                    end
                end
                if (sr != red_re[(j*NPT+k)*RW +: RW]) mism = 1'b1;
                if (si != red_im[(j*NPT+k)*RW +: RW]) mism = 1'b1;
            end
        end

        assign syn[NRED-1-j] = mism;
    end

endmodule

// File: rtl/pfe_fix.sv
module pfe_fix
    import pfe_pkg::*;
#(
    parameter int OW = 14,
    parameter int RW = 16
) (
    input  logic [NRED-1:0]        syn,
    input  logic [NCH*NPT*OW-1:0]  orig_re,
    input  logic [NCH*NPT*OW-1:0]  orig_im,
    input  logic [NRED*NPT*RW-1:0] red_re,
    input  logic [NRED*NPT*RW-1:0] red_im,
    output logic [NCH*NPT*OW-1:0]  fix_re,
    output logic [NCH*NPT*OW-1:0]  fix_im,
    output logic                   flag,
    output logic [CHW-1:0]         chan
);

    // syndrome decode
    always_comb begin
        flag = 1'b0;
        chan = '0;
        for (int ch = 0; ch < NALL; ch++) begin
            if (syn == code_of(ch)) begin
                flag = 1'b1;
                chan = CHW'(ch);
            end
        end
    end

    // rebuild each original channel from its check; select if flagged
    for (genvar c = 0; c < NCH; c++) begin : g_rb
        localparam int P = fix_chk(c);
        logic                 sel;
        logic signed [RW-1:0] rr, ri;

        assign sel = flag && (chan == CHW'(c));

        always_comb begin
            rr = '0;
            ri = '0;
            for (int k = 0; k < NPT; k++) begin
                rr = red_re[(P*NPT+k)*RW +: RW];
                ri = red_im[(P*NPT+k)*RW +: RW];
                for (int c2 = 0; c2 < NCH; c2++) begin
                    if (c2 != c && covers(P, c2)) begin
                        rr = rr - RW'($signed(orig_re[(c2*NPT+k)*OW +: OW]));
                        ri = ri - RW'($signed(orig_im[(c2*NPT+k)*OW +: OW]));
                    end
                end
                fix_re[(c*NPT+k)*OW +: OW] = sel ? rr[OW-1:0] : orig_re[(c*NPT+k)*OW +: OW];
                fix_im[(c*NPT+k)*OW +: OW] = sel ? ri[OW-1:0] : orig_im[(c*NPT+k)*OW +: OW];
            end
        end
    end

endmodule

// File: rtl/par_fft_ecc.sv
module par_fft_ecc
    import pfe_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [NCH*NPT*DW-1:0]        in_re,
    input  logic [NCH*NPT*DW-1:0]        in_im,
    input  logic                         inj_en,
    input  logic [CHW-1:0]               inj_chan,
    input  logic [BINW-1:0]              inj_bin,
    input  logic [DW+1:0]                inj_mask,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [NCH*NPT*(DW+2)-1:0]    out_re,
    output logic [NCH*NPT*(DW+2)-1:0]    out_im,
    output logic                         err_flag,
    output logic [CHW-1:0]               err_chan
);
    localparam int OW  = DW + 2;       // original transform output
    localparam int RIW = DW + 2;       // redundant transform input
    localparam int RW  = RIW + 2;      // redundant transform output
    localparam int IFW = NCH*NPT*DW;
    localparam int OFW = NCH*NPT*OW;
    localparam int RIF = NRED*NPT*RIW;
    localparam int RFW = NRED*NPT*RW;

    pfe_state_e state_q, state_d;

    // ---------------- state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_valid) state_d = S_XFORM;
            S_XFORM: state_d = S_CHECK;
            S_CHECK: state_d = S_FIX;
            S_FIX:   state_d = S_HOLD;
            S_HOLD:  if (out_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            S_IDLE:  in_ready  = 1'b1;
            S_HOLD:  out_valid = 1'b1;
            default: ;
        endcase
    end

    // ---------------- input capture ----------------
    logic [IFW-1:0]  x_re_q, x_im_q;
    logic            inj_en_q;
    logic [CHW-1:0]  inj_chan_q;
    logic [BINW-1:0] inj_bin_q;
    logic [OW-1:0]   inj_mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_re_q     <= '0;
            x_im_q     <= '0;
            inj_en_q   <= 1'b0;
            inj_chan_q <= '0;
            inj_bin_q  <= '0;
            inj_mask_q <= '0;
        end else if (state_q == S_IDLE && in_valid) begin
            x_re_q     <= in_re;
            x_im_q     <= in_im;
            inj_en_q   <= inj_en;
            inj_chan_q <= inj_chan;
            inj_bin_q  <= inj_bin;
            inj_mask_q <= inj_mask;
        end
    end

    // ---------------- redundant input sums ----------------
    logic [RIF-1:0] r_in_re, r_in_im;

    for (genvar j = 0; j < NRED; j++) begin : g_rsum
        logic signed [RIW-1:0] sr, si;
        always_comb begin
            sr = '0;
            si = '0;
            for (int n = 0; n < NPT; n++) begin
                sr = '0;
                si = '0;
                for (int c = 0; c < NCH; c++) begin
                    if (covers(j, c)) begin
                        sr = sr + RIW'($signed(x_re_q[(c*NPT+n)*DW +: DW]));
                        si = si + RIW'($signed(x_im_q[(c*NPT+n)*DW +: DW]));
                    end
                end
                r_in_re[(j*NPT+n)*RIW +: RIW] = sr;
                r_in_im[(j*NPT+n)*RIW +: RIW] = si;
            end
        end
    end

    // ---------------- transforms with fault injection ----------------
    logic [OFW-1:0] o_fft_re, o_fft_im, o_inj_re;
    logic [RFW-1:0] r_fft_re, r_fft_im, r_inj_re;

    for (genvar c = 0; c < NCH; c++) begin : g_orig
        logic [NPT*OW-1:0] v;
        pfe_fft4 #(.IW(DW)) u_fft (
            .x_re (x_re_q[c*NPT*DW +: NPT*DW]),
            .x_im (x_im_q[c*NPT*DW +: NPT*DW]),
            .y_re (o_fft_re[c*NPT*OW +: NPT*OW]),
            .y_im (o_fft_im[c*NPT*OW +: NPT*OW])
        );
        always_comb begin
            v = o_fft_re[c*NPT*OW +: NPT*OW];
            if (inj_en_q && inj_chan_q == CHW'(c))
                v[int'(inj_bin_q)*OW +: OW] = v[int'(inj_bin_q)*OW +: OW] ^ inj_mask_q;
            o_inj_re[c*NPT*OW +: NPT*OW] = v;
        end
    end

    for (genvar j = 0; j < NRED; j++) begin : g_red
        logic [NPT*RW-1:0] v;
        pfe_fft4 #(.IW(RIW)) u_fft (
            .x_re (r_in_re[j*NPT*RIW +: NPT*RIW]),
            .x_im (r_in_im[j*NPT*RIW +: NPT*RIW]),
            .y_re (r_fft_re[j*NPT*RW +: NPT*RW]),
            .y_im (r_fft_im[j*NPT*RW +: NPT*RW])
        );
        always_comb begin
            v = r_fft_re[j*NPT*RW +: NPT*RW];
            if (inj_en_q && inj_chan_q == CHW'(NCH + j))
                v[int'(inj_bin_q)*RW +: RW] = v[int'(inj_bin_q)*RW +: RW] ^ RW'(inj_mask_q);
            r_inj_re[j*NPT*RW +: NPT*RW] = v;
        end
    end

    // ---------------- pipeline registers ----------------
    logic [OFW-1:0]  orig_re_q, orig_im_q;
    logic [RFW-1:0]  red_re_q, red_im_q;
    logic [NRED-1:0] syn, syn_q;
    logic [OFW-1:0]  fix_re, fix_im;
    logic            fix_flag;
    logic [CHW-1:0]  fix_chan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            orig_re_q <= '0;
            orig_im_q <= '0;
            red_re_q  <= '0;
            red_im_q  <= '0;
        end else if (state_q == S_XFORM) begin
            orig_re_q <= o_inj_re;
            orig_im_q <= o_fft_im;
            red_re_q  <= r_inj_re;
            red_im_q  <= r_fft_im;
        end
    end

    pfe_check #(.OW(OW), .RW(RW)) u_check (
        .orig_re (orig_re_q),
        .orig_im (orig_im_q),
        .red_re  (red_re_q),
        .red_im  (red_im_q),
        .syn     (syn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  syn_q <= '0;
        else if (state_q == S_CHECK) syn_q <= syn;
    end

    pfe_fix #(.OW(OW), .RW(RW)) u_fix (
        .syn     (syn_q),
        .orig_re (orig_re_q),
        .orig_im (orig_im_q),
        .red_re  (red_re_q),
        .red_im  (red_im_q),
        .fix_re  (fix_re),
        .fix_im  (fix_im),
        .flag    (fix_flag),
        .chan    (fix_chan)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_re   <= '0;
            out_im   <= '0;
            err_flag <= 1'b0;
            err_chan <= '0;
        end else if (state_q == S_FIX) begin
            out_re   <= fix_re;
            out_im   <= fix_im;
            err_flag <= fix_flag;
            err_chan <= fix_chan;
        end
    end

    // ---------------- assertions ----------------
    a_r2_linearity_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && !inj_en_q) |=> (syn_q == '0));

    a_r5_redundant_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX && $countones(syn_q) == 1)
        |=> (out_re == orig_re_q && out_im == orig_im_q && err_flag));

    a_r6_clean_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX && syn_q == '0) |=> (!err_flag && err_chan == '0));

    a_r3_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_flag) |-> (int'(err_chan) < NALL));

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##4 out_valid);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && !in_ready && $stable(out_re) && $stable(out_im)
             && $stable(err_flag) && $stable(err_chan)));

endmodule

// File: tb/par_fft_ecc_tb.sv
module par_fft_ecc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 12;
    localparam int OW  = DW + 2;
    localparam int IFW = 16 * DW;
    localparam int OFW = 16 * OW;
    localparam int NV  = 14;

    typedef struct packed {
        logic [15:0] seed;
        logic        en;
        logic [2:0]  ch;
        logic [1:0]  bin;
        logic [13:0] mask;
        logic        xflag;
        logic [2:0]  xchan;
    } vec_t;

    // seed 0: all max, 1: all min, 2: alternating extremes, else pseudo-random
    localparam vec_t VT [NV] = '{
        '{16'd5,  1'b0, 3'd0, 2'd0, 14'h0000, 1'b0, 3'd0},  // R6 clean
        '{16'd9,  1'b1, 3'd0, 2'd0, 14'h0001, 1'b1, 3'd0},  // R4 ch0
        '{16'd13, 1'b1, 3'd1, 2'd1, 14'h3FFF, 1'b1, 3'd1},  // R4 ch1
        '{16'd21, 1'b1, 3'd2, 2'd2, 14'h0100, 1'b1, 3'd2},  // R4 ch2
        '{16'd33, 1'b1, 3'd3, 2'd3, 14'h2000, 1'b1, 3'd3},  // R4 ch3
        '{16'd44, 1'b1, 3'd4, 2'd0, 14'h0007, 1'b1, 3'd4},  // R5 red0
        '{16'd55, 1'b1, 3'd5, 2'd2, 14'h0080, 1'b1, 3'd5},  // R5 red1
        '{16'd66, 1'b1, 3'd6, 2'd3, 14'h0001, 1'b1, 3'd6},  // R5 red2
        '{16'd0,  1'b1, 3'd3, 2'd1, 14'h1555, 1'b1, 3'd3},  // R1 max
        '{16'd1,  1'b1, 3'd0, 2'd3, 14'h2AAA, 1'b1, 3'd0},  // R1 min
        '{16'd77, 1'b0, 3'd1, 2'd0, 14'h03FF, 1'b0, 3'd0},  // R9 en off
        '{16'd88, 1'b1, 3'd2, 2'd1, 14'h0000, 1'b0, 3'd0},  // R9 zero mask
        '{16'd99, 1'b1, 3'd7, 2'd2, 14'h00FF, 1'b0, 3'd0},  // R9 chan 7
        '{16'd2,  1'b1, 3'd2, 2'd1, 14'h2000, 1'b1, 3'd2}   // R1 alternating
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [IFW-1:0] in_re = '0, in_im = '0;
    logic           inj_en = 1'b0;
    logic [2:0]     inj_chan = '0;
    logic [1:0]     inj_bin = '0;
    logic [OW-1:0]  inj_mask = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [OFW-1:0] out_re, out_im;
    logic           err_flag;
    logic [2:0]     err_chan;

    logic [OFW-1:0] exp_re, exp_im;
    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    par_fft_ecc #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_re(in_re), .in_im(in_im), .inj_en(inj_en), .inj_chan(inj_chan),
        .inj_bin(inj_bin), .inj_mask(inj_mask), .out_valid(out_valid),
        .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
        .err_flag(err_flag), .err_chan(err_chan)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int smp(input int seed, input int c, input int n, input int part);
        int v;
        if (seed == 0)      v = 2047;
        else if (seed == 1) v = -2048;
        else if (seed == 2) v = ((n + c + part) % 2 == 0) ? 2047 : -2048;
        else v = ((seed*97 + c*331 + n*53 + part*17 + seed*n*c*7) % 4096) - 2048;
        return v;
    endfunction

    // builds inputs and the fault-free DFT by its definition
    task automatic build(input int seed);
        for (int c = 0; c < 4; c++) begin
            for (int n = 0; n < 4; n++) begin
                in_re[(c*4+n)*DW +: DW] = DW'(smp(seed, c, n, 0));
                in_im[(c*4+n)*DW +: DW] = DW'(smp(seed, c, n, 1));
            end
            for (int k = 0; k < 4; k++) begin
                int sr, si;
                sr = 0; si = 0;
                for (int n = 0; n < 4; n++) begin
                    int xr, xi;
                    xr = smp(seed, c, n, 0);
                    xi = smp(seed, c, n, 1);
                    case ((n*k) % 4)
                        0: begin sr += xr; si += xi; end
                        1: begin sr += xi; si -= xr; end
                        2: begin sr -= xr; si -= xi; end
                        default: begin sr -= xi; si += xr; end
                    endcase
                end
                exp_re[(c*4+k)*OW +: OW] = OW'(sr);
                exp_im[(c*4+k)*OW +: OW] = OW'(si);
            end
        end
    endtask

    task automatic cmp_data(input string req);
        bit ok;
        longint a, e;
        ok = 1'b1; a = 0; e = 0;
        for (int s = 0; s < 32 && ok; s++) begin
            logic [OW-1:0] av, ev;
            av = (s < 16) ? out_re[s*OW +: OW] : out_im[(s-16)*OW +: OW];
            ev = (s < 16) ? exp_re[s*OW +: OW] : exp_im[(s-16)*OW +: OW];
            if (av !== ev) begin
                ok = 1'b0;
                a = longint'($signed(av));
                e = longint'($signed(ev));
            end
        end
        chk(ok, req, a, e);
    endtask

    // one transaction; hold = cycles of back-pressure in HOLD
    task automatic run_vec(input int i, input int hold);
        vec_t v;
        v = VT[i];
        @(negedge clk);
        build(int'(v.seed));
        inj_en = v.en; inj_chan = v.ch; inj_bin = v.bin; inj_mask = v.mask;
        in_valid = 1'b1;
        chk(in_ready === 1'b1, "R7 ready in idle", longint'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; inj_en = 1'b0; inj_mask = '0;
        chk(in_ready === 1'b0, "R7 busy not ready", longint'(in_ready), 0);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R7 latency early", longint'(out_valid), 0);
        @(negedge clk);
        chk(out_valid === 1'b1, "R7 latency at 4", longint'(out_valid), 1);
        if (v.xchan >= 3'd4 || !v.xflag) cmp_data("R5/R6/R9 data");
        else                             cmp_data("R4/R1 corrected data");
        chk(err_flag === v.xflag, "R3/R6 err_flag", longint'(err_flag), longint'(v.xflag));
        chk(err_chan === v.xchan, "R3 err_chan", longint'(err_chan), longint'(v.xchan));
        for (int h = 0; h < hold; h++) begin
            logic [OFW-1:0] sre;
            logic [2:0]     sch;
            sre = out_re; sch = err_chan;
            in_valid = 1'b1;
            @(negedge clk);
            chk(out_valid === 1'b1 && in_ready === 1'b0, "R8 held/not ready",
                longint'({out_valid, in_ready}), 2);
            chk(out_re === sre && err_chan === sch, "R8 stable", longint'(err_chan), longint'(sch));
            in_valid = 1'b0;
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R7 back to idle",
            longint'({out_valid, in_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(in_ready === 1'b1, "R10 in_ready reset", longint'(in_ready), 1);
        chk(out_valid === 1'b0, "R10 out_valid reset", longint'(out_valid), 0);
        chk(err_flag === 1'b0, "R10 err_flag reset", longint'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(i, (i == 3) ? 5 : 0);

        // R10 reset mid-transaction after a flagged result is pending
        @(negedge clk);
        build(33);
        inj_en = 1'b1; inj_chan = 3'd1; inj_bin = 2'd0; inj_mask = 14'h0011;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; inj_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R10 mid-run reset",
            longint'({in_ready, out_valid}), 2);
        @(negedge clk);
        chk(err_flag === 1'b0, "R10 flag after reset", longint'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 recovers after reset with a clean vector
        run_vec(0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule